// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the device-side command controller for a byte-wide flash array that is 128K addresses deep and 8 bits wide. It samples the chip-enable, output-enable and write-enable strobes together with the address and data buses, all synchronous to the block clock. It decodes one-cycle and two-cycle command sequences and issues start pulses for program, erase and automatic erase to a behavioural array model that has a busy timer. It also chooses what a read cycle returns: array data, identifier codes, verify data, or the automatic-erase status bit.

The high-voltage enable is a single logic input. While it is low, the controller is a plain read-only memory with an identifier-by-pin option, and it ignores command writes. While it is high, command writes select the mode.

The array model keeps the full 17-bit address space. It folds that space onto a reduced storage depth, so elaboration stays small. Erase sets bytes to FFH. Programming ANDs the new data into the stored byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The command mode is read-array whenever high-voltage enable has just been asserted: after `hv_en` is low for at least one clock, reads return array data until a new command is written.
- R2: With `hv_en` low, every write cycle is ignored: mode and array content do not change. A read returns array data, or returns identifier codes when `a9_hv` is high.
- R3: In identifier mode (first-cycle code 90H, or `a9_hv` with `hv_en` low), a read with address bit 0 low returns 07H and a read with address bit 0 high returns 19H. Code 00H returns to array reads.
- R4: Code 40H followed by a second write programs the byte at the second cycle's address. The address is taken at the falling edge of `we_n` and the data at its rising edge, both with `ce_n` low. The stored byte becomes old AND new.
- R5: After code C0H, reads return the byte at the most recently programmed address, whatever address is on the bus.
- R6: Code 20H followed by 20H erases the whole array to FFH once the erase timer expires.
- R7: Code A0H latches the address of that write cycle. The following reads return the byte at that latched address.
- R8: Code 30H followed by 30H starts automatic erase. Every byte reads 00H while the erase runs, and FFH after it ends. In the status mode it enters, reads drive only I/O7, with the other bits of `dq_oe` at 0. I/O7 reads 0 while busy and 1 when done.
- R9: If the second cycle of an erase, automatic-erase or reset sequence carries any value other than the repeated code, the sequence aborts to read mode and no operation starts.
- R10: Code FFH followed by FFH returns the controller to read-array mode.
- R11: `dq_oe` is all zero unless `ce_n` and `oe_n` are low and `we_n` is high.
- R12: After reset the array reads FFH everywhere, the mode is read-array, and no operation is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_en | input | 1 | Program voltage present (logic level) |
| a9_hv | input | 1 | Identifier-by-pin request while hv_en is low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data bus |
| dq_out | output | 8 | Read data bus |
| dq_oe | output | 8 | Per-bit output drive enable |

## Verification
The embedded properties check the following on every cycle:
- The mode falls back to read-array while the program voltage is off.
- A mismatched confirm code aborts without a start pulse.
- Start pulses are mutually exclusive, and each one makes the model busy.
- The outputs are never driven outside an active read.

Only the bench scenarios can show the data-level results:
- Program uses AND semantics, and the verify and erase-verify reads come from latched addresses.
- Automatic erase pre-writes 00H, and the status bit moves from busy to done.
- Reset by double FFH, and the identifier codes by command and by pin.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, identifier values and mode encoding for the
// flash command controller. Assumes byte-wide data.
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_EVRFY  = 8'hA0;
    localparam logic [7:0] CMD_AUTO   = 8'h30;
    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_PVRFY  = 8'hC0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;

    localparam logic [7:0] ID_MAKER   = 8'h07;
    localparam logic [7:0] ID_DEVICE  = 8'h19;

    typedef enum logic [3:0] {
        M_READ,
        M_IDENT,
        M_ESETUP,
        M_EVERIFY,
        M_ASETUP,
        M_STATUS,
        M_PSETUP,
        M_PVERIFY,
        M_RSETUP
    } mode_t;

endpackage

// File: rtl/flash_strobe_capture.sv
// Strobe edge detection for the bus side. It takes the (folded) address
// at the falling edge of we_n while ce_n is low, and flags a write
// strobe at the rising edge of we_n while ce_n is low. Data is taken
// from the bus in that same cycle. Assumes the strobes are synchronous
// to clk and held for at least one clock in each level.
module flash_strobe_capture #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_act
);

    logic          we_q;
    logic [AW-1:0] a_cap;

    // Remember the last we_n level and capture the address on its fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q  <= 1'b1;
            a_cap <= '0;
        end else begin
            we_q <= we_n;
            if (!ce_n && we_q && !we_n)
                a_cap <= addr;
        end
    end

    // Rising edge of we_n with the chip selected ends a write cycle.
    assign wr_stb  = !ce_n && !we_q && we_n;
    assign wr_addr = a_cap;
    assign wr_data = din;
    assign rd_act  = !ce_n && !oe_n && we_n;

endmodule

// File: rtl/flash_cmd_decoder.sv
// Command latch and sequence decoder. It holds the current mode, decodes
// first-cycle codes and checks the confirm cycle of two-cycle commands.
// It raises one-cycle start pulses toward the array model and latches the
// address that the verify modes read from. Assumes wr_stb lasts one clock.
module flash_cmd_decoder #(
    parameter int AW = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hv_en,
    input  logic                   wr_stb,
    input  logic [AW-1:0]          wr_addr,
    input  logic [7:0]             wr_data,
    output flash_cmd_pkg::mode_t   mode,
    output logic [AW-1:0]          ptr_addr,
    output logic                   prog_go,
    output logic                   erase_go,
    output logic                   auto_go
);
    import flash_cmd_pkg::*;

    mode_t         mode_nxt;
    logic          ptr_load;
    logic          wr_ok;

    assign wr_ok = hv_en && wr_stb;

    // Next mode and start pulses from the current mode and the write cycle.
    always_comb begin
        mode_nxt = mode;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        auto_go  = 1'b0;
        ptr_load = 1'b0;
        if (!hv_en) begin
            mode_nxt = M_READ;
        end else if (wr_ok) begin
            case (mode)
                M_ESETUP: begin
                    erase_go = (wr_data == CMD_ERASE);
                    mode_nxt = M_READ;
                end
                M_ASETUP: begin
                    auto_go  = (wr_data == CMD_AUTO);
                    mode_nxt = (wr_data == CMD_AUTO) ? M_STATUS : M_READ;
                end
                M_RSETUP: mode_nxt = M_READ;
                M_PSETUP: begin
                    prog_go  = 1'b1;
                    ptr_load = 1'b1;
                    mode_nxt = M_READ;
                end
                default: begin
                    case (wr_data)
                        CMD_IDENT: mode_nxt = M_IDENT;
                        CMD_ERASE: mode_nxt = M_ESETUP;
                        CMD_EVRFY: begin
                            mode_nxt = M_EVERIFY;
                            ptr_load = 1'b1;
                        end
                        CMD_AUTO:  mode_nxt = M_ASETUP;
                        CMD_PROG:  mode_nxt = M_PSETUP;
                        CMD_PVRFY: mode_nxt = M_PVERIFY;
                        CMD_RESET: mode_nxt = M_RSETUP;
                        default:   mode_nxt = M_READ;
                    endcase
                end
            endcase
        end
    end

    // Mode register and verify-address latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= M_READ;
            ptr_addr <= '0;
        end else begin
            mode <= mode_nxt;
            if (ptr_load)
                ptr_addr <= wr_addr;
        end
    end

    // R2
    property hv_off_read_p;
        @(posedge clk) disable iff (!rst_n) !hv_en |=> (mode == M_READ);
    endproperty
    hv_off_read_chk: assert property (hv_off_read_p);

    // R9
    property confirm_abort_p;
        @(posedge clk) disable iff (!rst_n)
            (hv_en && wr_stb && (((mode == M_ESETUP) && (wr_data != CMD_ERASE)) ||
                                 ((mode == M_ASETUP) && (wr_data != CMD_AUTO))))
            |=> (mode == M_READ) && $past(!erase_go && !auto_go);
    endproperty
    confirm_abort_chk: assert property (confirm_abort_p);

endmodule

// File: rtl/flash_array_model.sv
// Behavioural array stand-in with a busy timer. Program ANDs data into a
// byte. Erase clears all bytes to FFH when its timer ends. Automatic erase
// writes 00H everywhere at start and FFH at the end of its timer. Storage
// depth is 2**AW bytes, reduced for elaboration.
module flash_array_model #(
    parameter int AW        = 10,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 16,
    parameter int AUTO_CYC  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_go,
    input  logic          erase_go,
    input  logic          auto_go,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    op_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);

    localparam int DEPTH = 1 << AW;
    localparam int CNT_W = $clog2(PROG_CYC + ERASE_CYC + AUTO_CYC + 1);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             wipe_pend;

    // Apply operations to the storage and run the busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            cnt       <= '0;
            wipe_pend <= 1'b0;
        end else if (prog_go) begin
            mem[op_addr] <= mem[op_addr] & op_data;
            cnt          <= CNT_W'(PROG_CYC);
        end else if (erase_go) begin
            cnt       <= CNT_W'(ERASE_CYC);
            wipe_pend <= 1'b1;
        end else if (auto_go) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            cnt       <= CNT_W'(AUTO_CYC);
            wipe_pend <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1) && wipe_pend) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                wipe_pend <= 1'b0;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (cnt != '0);

    // R6
    property erase_busy_p;
        @(posedge clk) disable iff (!rst_n) (erase_go || auto_go) |=> busy;
    endproperty
    erase_busy_chk: assert property (erase_busy_p);

    // R4
    property go_onehot_p;
        @(posedge clk) disable iff (!rst_n) $onehot0({prog_go, erase_go, auto_go});
    endproperty
    go_onehot_chk: assert property (go_onehot_p);

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interface. It folds the bus address onto the
// model depth and wires strobe capture, decoder and array model. It also
// selects what a read cycle returns. Assumes bus signals are synchronous
// to clk.
module flash_cmd_ctrl #(
    parameter int ADDR_W    = 17,
    parameter int ARRAY_AW  = 10,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 16,
    parameter int AUTO_CYC  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_en,
    input  logic              a9_hv,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dq_out,
    output logic [7:0]        dq_oe
);
    import flash_cmd_pkg::*;

    logic [ARRAY_AW-1:0] fold_addr;
    logic                wr_stb, rd_act;
    logic [ARRAY_AW-1:0] wr_addr, ptr_addr, rd_addr;
    logic [7:0]          wr_data, rd_data, id_code;
    logic                prog_go, erase_go, auto_go, busy;
    mode_t               mode;

    // Map the full address space onto the model storage.
    generate
        if (ADDR_W > ARRAY_AW) begin : g_fold
            assign fold_addr = addr[ARRAY_AW-1:0] ^ ARRAY_AW'(addr[ADDR_W-1:ARRAY_AW]);
        end else begin : g_direct
            assign fold_addr = ARRAY_AW'(addr);
        end
    endgenerate

    flash_strobe_capture #(.AW(ARRAY_AW)) i_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(fold_addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_act(rd_act)
    );

    flash_cmd_decoder #(.AW(ARRAY_AW)) i_dec (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode), .ptr_addr(ptr_addr),
        .prog_go(prog_go), .erase_go(erase_go), .auto_go(auto_go)
    );

    flash_array_model #(
        .AW(ARRAY_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .AUTO_CYC(AUTO_CYC)
    ) i_array (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
        .auto_go(auto_go), .op_addr(wr_addr), .op_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // Verify modes read from the latched address, others from the bus.
    assign rd_addr = (mode == M_EVERIFY || mode == M_PVERIFY) ? ptr_addr : fold_addr;
    assign id_code = addr[0] ? ID_DEVICE : ID_MAKER;

    // Read data selection and per-bit drive enables.
    always_comb begin
        dq_out = rd_data;
        dq_oe  = 8'hFF;
        if (!rd_act) begin
            dq_oe = 8'h00;
        end else if (!hv_en) begin
            if (a9_hv) dq_out = id_code;
        end else begin
            case (mode)
                M_IDENT:  dq_out = id_code;
                M_STATUS: begin
                    dq_out = {!busy, 7'b0};
                    dq_oe  = 8'h80;
                end
                default:  dq_out = rd_data;
            endcase
        end
    end

    // R11
    property out_disable_p;
        @(posedge clk) disable iff (!rst_n) (ce_n || oe_n || !we_n) |-> (dq_oe == 8'h00);
    endproperty
    out_disable_chk: assert property (out_disable_p);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_en = 1'b0;
    logic        a9_hv = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out, dq_oe;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .a9_hv(a9_hv), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Vector: kind(2) addr(17) data(8) exp(8) exp_oe(8) req(4)
    // kind 0 = write cycle, 1 = read and compare, 2 = idle for data cycles
    localparam int NV = 49;
    localparam logic [46:0] VEC [NV] = '{
        {2'd1, 17'h5, 8'h00, 8'hFF, 8'hFF, 4'd12},  // R12 erased after reset
        {2'd0, 17'h0, 8'h40, 8'h00, 8'h00, 4'd4},   // R4 program setup
        {2'd0, 17'h5, 8'h3C, 8'h00, 8'h00, 4'd4},
        {2'd1, 17'h5, 8'h00, 8'h3C, 8'hFF, 4'd4},
        {2'd0, 17'h0, 8'h40, 8'h00, 8'h00, 4'd4},
        {2'd0, 17'h5, 8'hF0, 8'h00, 8'h00, 4'd4},
        {2'd1, 17'h5, 8'h00, 8'h30, 8'hFF, 4'd4},   // R4 AND of 3C and F0
        {2'd0, 17'h0, 8'hC0, 8'h00, 8'h00, 4'd5},   // R5 program verify
        {2'd1, 17'h9, 8'h00, 8'h30, 8'hFF, 4'd5},
        {2'd0, 17'h0, 8'h90, 8'h00, 8'h00, 4'd3},   // R3 identifier
        {2'd1, 17'h0, 8'h00, 8'h07, 8'hFF, 4'd3},
        {2'd1, 17'h1, 8'h00, 8'h19, 8'hFF, 4'd3},
        {2'd0, 17'h0, 8'h00, 8'h00, 8'h00, 4'd3},
        {2'd1, 17'h5, 8'h00, 8'h30, 8'hFF, 4'd3},
        {2'd0, 17'h0, 8'h20, 8'h00, 8'h00, 4'd9},   // R9 bad erase confirm
        {2'd0, 17'h0, 8'h21, 8'h00, 8'h00, 4'd9},
        {2'd2, 17'h0, 8'd20, 8'h00, 8'h00, 4'd9},
        {2'd1, 17'h5, 8'h00, 8'h30, 8'hFF, 4'd9},
        {2'd0, 17'h0, 8'h20, 8'h00, 8'h00, 4'd6},   // R6 erase
        {2'd0, 17'h0, 8'h20, 8'h00, 8'h00, 4'd6},
        {2'd2, 17'h0, 8'd20, 8'h00, 8'h00, 4'd6},
        {2'd1, 17'h5, 8'h00, 8'hFF, 8'hFF, 4'd6},
        {2'd0, 17'h0, 8'h40, 8'h00, 8'h00, 4'd7},   // R7 prepare byte 6
        {2'd0, 17'h6, 8'h5A, 8'h00, 8'h00, 4'd7},
        {2'd2, 17'h0, 8'd6,  8'h00, 8'h00, 4'd7},
        {2'd0, 17'h6, 8'hA0, 8'h00, 8'h00, 4'd7},   // R7 erase verify at 6
        {2'd1, 17'h0, 8'h00, 8'h5A, 8'hFF, 4'd7},
        {2'd0, 17'h0, 8'h30, 8'h00, 8'h00, 4'd8},   // R8 auto erase
        {2'd0, 17'h0, 8'h30, 8'h00, 8'h00, 4'd8},
        {2'd1, 17'h0, 8'h00, 8'h00, 8'h80, 4'd8},   // R8 busy status
        {2'd0, 17'h0, 8'h00, 8'h00, 8'h00, 4'd8},
        {2'd1, 17'h6, 8'h00, 8'h00, 8'hFF, 4'd8},   // R8 pre-write 00
        {2'd2, 17'h0, 8'd40, 8'h00, 8'h00, 4'd8},
        {2'd1, 17'h6, 8'h00, 8'hFF, 8'hFF, 4'd8},
        {2'd0, 17'h0, 8'h30, 8'h00, 8'h00, 4'd8},
        {2'd0, 17'h0, 8'h30, 8'h00, 8'h00, 4'd8},
        {2'd2, 17'h0, 8'd40, 8'h00, 8'h00, 4'd8},
        {2'd1, 17'h0, 8'h00, 8'h80, 8'h80, 4'd8},   // R8 done status
        {2'd0, 17'h0, 8'h40, 8'h00, 8'h00, 4'd10},  // R10 prepare byte 3
        {2'd0, 17'h3, 8'hA5, 8'h00, 8'h00, 4'd10},
        {2'd2, 17'h0, 8'd6,  8'h00, 8'h00, 4'd10},
        {2'd0, 17'h0, 8'h90, 8'h00, 8'h00, 4'd10},
        {2'd0, 17'h0, 8'hFF, 8'h00, 8'h00, 4'd10},
        {2'd0, 17'h0, 8'hFF, 8'h00, 8'h00, 4'd10},
        {2'd1, 17'h1, 8'h00, 8'hFF, 8'hFF, 4'd10},  // R10 back to array reads
        {2'd1, 17'h3, 8'h00, 8'hA5, 8'hFF, 4'd10},
        {2'd0, 17'h0, 8'h30, 8'h00, 8'h00, 4'd9},   // R9 bad auto confirm
        {2'd0, 17'h0, 8'h31, 8'h00, 8'h00, 4'd9},
        {2'd1, 17'h3, 8'h00, 8'hA5, 8'hFF, 4'd9}
    };

    task automatic wr_cycle(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic rd_check(input logic [16:0] a, input logic [7:0] exp,
                            input logic [7:0] eoe, input int req);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if (dq_oe !== eoe || (dq_out & eoe) !== (exp & eoe)) begin
            n_err++;
            $display("FAIL R%0d addr=%h: out=%h oe=%h expected out=%h oe=%h",
                     req, a, dq_out, dq_oe, exp, eoe);
        end
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 idle strobes: nothing driven
        n_chk++;
        if (dq_oe !== 8'h00) begin
            n_err++;
            $display("FAIL R11 idle: oe=%h expected oe=00", dq_oe);
        end
        hv_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][46:45])
                2'd0: wr_cycle(VEC[i][44:28], VEC[i][27:20]);
                2'd1: rd_check(VEC[i][44:28], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
                default: repeat (int'(VEC[i][27:20])) @(negedge clk);
            endcase
        end

        // R11 write strobe low with oe low: no drive
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if (dq_oe !== 8'h00) begin
            n_err++;
            $display("FAIL R11 we low: oe=%h expected oe=00", dq_oe);
        end
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

        // R2 writes ignored with program voltage off
        hv_en = 1'b0;
        wr_cycle(17'h0, 8'h90);
        rd_check(17'h1, 8'hFF, 8'hFF, 2);
        wr_cycle(17'h0, 8'h40);
        wr_cycle(17'h3, 8'h00);
        rd_check(17'h3, 8'hA5, 8'hFF, 2);
        // R2 R3 identifier by pin
        a9_hv = 1'b1;
        rd_check(17'h0, 8'h07, 8'hFF, 3);
        rd_check(17'h1, 8'h19, 8'hFF, 3);
        a9_hv = 1'b0;
        rd_check(17'h1, 8'hFF, 8'hFF, 2);

        // R1 voltage re-applied resets the command latch to array reads
        hv_en = 1'b1;
        @(negedge clk);
        wr_cycle(17'h0, 8'h90);
        rd_check(17'h1, 8'h19, 8'hFF, 1);
        hv_en = 1'b0;
        @(negedge clk);
        hv_en = 1'b1;
        rd_check(17'h1, 8'hFF, 8'hFF, 1);
        rd_check(17'h3, 8'hA5, 8'hFF, 1);

        // R12 reset again restores erased array
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_check(17'h3, 8'hFF, 8'hFF, 12);

        done = 1'b1;
        finish_run();
    end

endmodule